// File: doc/BRIEF.md
# Serial Memory Status and Write-Enable Front End

This block sits on the slave side of a serial-bus memory and owns the status byte and the write-enable latch. It watches chip select, serial clock and the serial data input, all of which are resynchronised into the local clock domain. It collects an opcode of eight bits, most significant bit first, and acts on four instructions: read status (05h), set write enable (06h), clear write enable (04h) and write status (01h followed by one data byte).

A read-status instruction streams the status byte back on the serial output, changing data on falling serial clock edges so that the master samples on rising edges (mode 0). The byte repeats for as long as chip select stays low. The write-enable latch and the protection field change only when chip select returns high after a frame of exactly the right length. A write-status frame, when permitted, updates the two protection bits and pulses a start output towards an external write-cycle timer. That timer's busy signal appears as bit 0 of the status byte, and its falling edge clears the latch. Array-write logic elsewhere uses the write-permission output.

Top module: `spi_sts_front`

## Requirements
- R1: The opcode is taken from the data input on rising serial clock edges while chip select is low, most significant bit first. A byte sent in reversed bit order is not recognised.
- R2: For opcode 05h, the falling serial clock edge after the eighth rising edge drives status bit 7. Each later falling edge drives the next lower bit. After bit 0 the byte reloads and repeats while chip select stays low.
- R3: The output enable is low while chip select is high, during the opcode phase, and for every opcode other than 05h.
- R4: The status byte holds busy in bit 0, the write-enable latch in bit 1 and protection in bits 3:2. Bits 7:4 read 0.
- R5: Opcode 06h in a frame of exactly 8 clocks sets the latch when chip select rises, and not before.
- R6: Opcode 04h in a frame of exactly 8 clocks clears the latch when chip select rises.
- R7: A set or clear frame that has any clock count other than 8 leaves the latch unchanged.
- R8: A frame of exactly 16 clocks holding opcode 01h and a data byte copies data bits 3:2 into the protection bits at the chip-select rising edge and gives a one-cycle start pulse. This happens only if the latch is 1. Otherwise protection stays as it was and no pulse appears.
- R9: The latch clears in the cycle after busy falls.
- R10: While busy is high, set, clear and write-status frames have no effect. Status reads still work and show bit 0 as 1.
- R11: Write permission is high only when the latch is 1, busy is low, and busy was low on the previous clock.
- R12: After reset the latch is 0, protection equals the reset parameter, the output enable is low and the start pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; serial pins are oversampled against it |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select from the master, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data from the master |
| busy | input | 1 | High while the external write cycle runs |
| so | output | 1 | Serial data towards the master |
| so_oe | output | 1 | Output pad enable; low means high-impedance |
| wr_permit | output | 1 | Grants array and status writes |
| nv_start | output | 1 | One-cycle start request to the write timer |

## Verification
The bench builds the block with three synchroniser stages instead of the default two. Its model therefore has to track a longer pin-to-action latency, and a latency error in the sampling path shows up as a mismatch. The protection reset value is set to binary 10. A status read taken straight after reset can then tell the reset value apart from cleared bits, and a later write of 01 shows that both protection bits really change.

// File: rtl/spi_sts_pkg.sv
// Shared definitions for the serial status front end: opcode values,
// status byte layout and frame lengths. Assumes an 8-bit opcode.
package spi_sts_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OPC_WRSR = 8'h01;
    localparam logic [OP_W-1:0] OPC_WRDI = 8'h04;
    localparam logic [OP_W-1:0] OPC_RDSR = 8'h05;
    localparam logic [OP_W-1:0] OPC_WREN = 8'h06;

    // Positions of the protection field inside the status/data byte
    localparam int PROT_LSB = 2;
    localparam int PROT_MSB = 3;

    typedef struct packed {
        logic [3:0] zero;
        logic [1:0] prot;
        logic       wel;
        logic       busy;
    } status_t;

endpackage

// File: rtl/spi_sts_sync.sv
// Resynchronises a vector of asynchronous pins into clk and flags edges.
// Assumes each pin level is held for at least one clk period.
module spi_sts_sync #(
    parameter int             STAGES = 2,
    parameter int             W      = 3,
    parameter logic [W-1:0]   IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] chain [STAGES];
    logic [W-1:0] last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First capture flop of the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= IDLE;
                else        chain[0] <= din;
            end
        end else begin : g_rest
            // Further metastability filtering
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= IDLE;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign lvl = chain[STAGES-1];

    // Delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= IDLE;
        else        last_q <= lvl;
    end

    assign rise = lvl & ~last_q;
    assign fall = ~lvl & last_q;

endmodule

// File: rtl/spi_sts_rx.sv
// Collects opcode and first argument byte from the serial input.
// Assumes sel is the synchronised active-high select and sck_rise a one-cycle pulse.
module spi_sts_rx
    import spi_sts_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            sck_rise,
    input  logic            si,
    output logic [CW-1:0]   cnt,
    output logic [OP_W-1:0] op,
    output logic [OP_W-1:0] arg
);

    localparam logic [CW-1:0] CNT_SAT = CW'(2*OP_W + 1);
    localparam logic [CW-1:0] OP_LAST = CW'(OP_W - 1);
    localparam logic [CW-1:0] AR_LAST = CW'(2*OP_W - 1);

    logic [OP_W-1:0] sh;
    logic [OP_W-1:0] sh_next;

    assign sh_next = {sh[OP_W-2:0], si};

    // Shift in bits, count clocks (saturating), latch opcode and argument
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
            op  <= '0;
            arg <= '0;
        end else if (!sel) begin
            cnt <= '0;
        end else if (sck_rise) begin
            sh <= sh_next;
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            if (cnt == OP_LAST) op  <= sh_next;
            if (cnt == AR_LAST) arg <= sh_next;
        end
    end

endmodule

// File: rtl/spi_sts_regs.sv
// Holds the write-enable latch and protection bits; evaluates frames at
// chip-select release. Assumes busy is already in the clk domain.
module spi_sts_regs
    import spi_sts_pkg::*;
#(
    parameter int          CW       = 5,
    parameter logic [1:0]  BP_RESET = 2'b00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_end,
    input  logic [CW-1:0]   cnt,
    input  logic [OP_W-1:0] op,
    input  logic [OP_W-1:0] arg,
    input  logic            busy,
    output logic            wel,
    output logic [1:0]      prot,
    output logic            nv_start,
    output logic            permit
);

    localparam logic [CW-1:0] LEN_CMD = CW'(OP_W);
    localparam logic [CW-1:0] LEN_WR  = CW'(2*OP_W);

    logic busy_q;
    logic busy_done;
    logic cmd_ok;
    logic wr_ok;
    logic wel_d;
    logic unused_arg;

    assign busy_done  = busy_q & ~busy;
    assign cmd_ok     = frame_end && (cnt == LEN_CMD) && !busy;
    assign wr_ok      = frame_end && (cnt == LEN_WR) && !busy
                        && (op == OPC_WRSR) && wel;
    assign unused_arg = ^{arg[OP_W-1:PROT_MSB+1], arg[PROT_LSB-1:0]};

    // Next latch value: cycle completion clears, then commands override
    always_comb begin
        wel_d = wel;
        if (busy_done) wel_d = 1'b0;
        if (cmd_ok && op == OPC_WREN) wel_d = 1'b1;
        if (cmd_ok && op == OPC_WRDI) wel_d = 1'b0;
    end

    // State update for latch, protection, start pulse and busy history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel      <= 1'b0;
            prot     <= BP_RESET;
            nv_start <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            wel      <= wel_d;
            nv_start <= wr_ok;
            busy_q   <= busy;
            if (wr_ok) prot <= arg[PROT_MSB:PROT_LSB];
        end
    end

    assign permit = wel & ~busy & ~busy_q;

endmodule

// File: rtl/spi_sts_tx.sv
// Streams the status byte on the serial output in mode 0, repeating it.
// Assumes sck_fall is a one-cycle pulse and sel the synchronised select.
module spi_sts_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       sck_fall,
    input  logic       rd_go,
    input  logic [7:0] status,
    output logic       so,
    output logic       so_oe
);

    logic [7:0] sh;
    logic [2:0] idx;

    // Load or shift on falling serial clock; release pad on deselect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            idx   <= '0;
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else if (!sel) begin
            sh    <= '0;
            idx   <= '0;
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else if (sck_fall && rd_go) begin
            if (!so_oe || idx == 3'd7) begin
                sh    <= {status[6:0], 1'b0};
                so    <= status[7];
                idx   <= '0;
                so_oe <= 1'b1;
            end else begin
                sh  <= {sh[6:0], 1'b0};
                so  <= sh[7];
                idx <= idx + 3'd1;
            end
        end
    end

endmodule

// File: rtl/spi_sts_front.sv
// Top of the serial status front end: synchroniser, receiver, register
// block and transmitter. Assumes serial pins are slow against clk.
module spi_sts_front
    import spi_sts_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] BP_RESET    = 2'b00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic busy,
    output logic so,
    output logic so_oe,
    output logic wr_permit,
    output logic nv_start
);

    localparam int CW = $clog2(2*OP_W + 2);

    logic [2:0]      pin_lvl, pin_rise, pin_fall;
    logic            csn_lvl, csn_rise, sck_rise, sck_fall, si_lvl;
    logic [CW-1:0]   cnt;
    logic [OP_W-1:0] op, arg;
    logic            wel;
    logic [1:0]      bp;
    logic            rd_go;
    status_t         st;
    logic            unused_edges;

    spi_sts_sync #(
        .STAGES (SYNC_STAGES),
        .W      (3),
        .IDLE   (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sck, si}),
        .lvl   (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign csn_lvl      = pin_lvl[2];
    assign csn_rise     = pin_rise[2];
    assign sck_rise     = pin_rise[1];
    assign sck_fall     = pin_fall[1];
    assign si_lvl       = pin_lvl[0];
    assign unused_edges = ^{pin_fall[2], pin_fall[0], pin_rise[0], pin_lvl[1]};

    spi_sts_rx #(.CW(CW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (~csn_lvl),
        .sck_rise (sck_rise),
        .si       (si_lvl),
        .cnt      (cnt),
        .op       (op),
        .arg      (arg)
    );

    spi_sts_regs #(.CW(CW), .BP_RESET(BP_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (csn_rise),
        .cnt       (cnt),
        .op        (op),
        .arg       (arg),
        .busy      (busy),
        .wel       (wel),
        .prot      (bp),
        .nv_start  (nv_start),
        .permit    (wr_permit)
    );

    assign st    = '{zero: 4'b0000, prot: bp, wel: wel, busy: busy};
    assign rd_go = (cnt >= CW'(OP_W)) && (op == OPC_RDSR);

    spi_sts_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (~csn_lvl),
        .sck_fall (sck_fall),
        .rd_go    (rd_go),
        .status   (st),
        .so       (so),
        .so_oe    (so_oe)
    );

endmodule

// File: rtl/spi_sts_front_chk.sv
// Temporal checks for the status front end, bound into the top module.
module spi_sts_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       csn_lvl,
    input logic       csn_rise,
    input logic       sck_fall,
    input logic       busy,
    input logic       wel,
    input logic [1:0] bp,
    input logic       so,
    input logic       so_oe,
    input logic       nv_start
);

    p_oe_off_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csn_lvl |=> !so_oe);

    p_so_moves_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !csn_lvl) |=> $stable(so));

    p_wel_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn_rise && !($past(busy) && !busy)) |=> $stable(wel));

    p_prot_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |=> $stable(bp));

    p_start_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nv_start |-> $past(wel));

    p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy && !csn_rise) |=> !wel);

    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && csn_rise) |=> ($stable(wel) && $stable(bp)));

endmodule

bind spi_sts_front spi_sts_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_lvl  (csn_lvl),
    .csn_rise (csn_rise),
    .sck_fall (sck_fall),
    .busy     (busy),
    .wel      (wel),
    .bp       (bp),
    .so       (so),
    .so_oe    (so_oe),
    .nv_start (nv_start)
);

// File: tb/tb_spi_sts_front.sv
module tb_spi_sts_front;

    localparam int         CLK_T   = 10;
    localparam int         SYNC_N  = 3;
    localparam int         HALF    = 7;
    localparam logic [1:0] BP_INIT = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, busy = 1'b0;
    logic so, so_oe, wr_permit, nv_start;

    spi_sts_front #(.SYNC_STAGES(SYNC_N), .BP_RESET(BP_INIT)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .busy(busy), .so(so), .so_oe(so_oe),
        .wr_permit(wr_permit), .nv_start(nv_start)
    );

    always #(CLK_T/2) clk = ~clk;

    int  checks = 0, errors = 0;
    bit  done = 0;
    int  nv_seen = 0;
    bit  oe_seen = 0;
    logic [7:0] cap [4];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int q_cs[$], q_sck[$], q_si[$];
    int m_cnt, m_op, m_arg, m_sh, m_wel, m_bp, m_busy_q, m_nv;
    int m_oe, m_so, m_idx, m_osh;

    always @(posedge clk) begin
        int ccs, pcs, cck, pck, csi, stat, n_wel, n_bp, n_nv;
        bit crise, krise, kfall;
        if (!rst_n) begin
            m_cnt = 0; m_op = 0; m_arg = 0; m_sh = 0;
            m_wel = 0; m_bp = BP_INIT; m_busy_q = 0; m_nv = 0;
            m_oe = 0; m_so = 0; m_idx = 0; m_osh = 0;
            q_cs.delete(); q_sck.delete(); q_si.delete();
            for (int i = 0; i <= SYNC_N; i++) begin
                q_cs.push_back(1); q_sck.push_back(0); q_si.push_back(0);
            end
        end else begin
            q_cs.push_back(cs_n); q_sck.push_back(sck); q_si.push_back(si);
            ccs = q_cs[q_cs.size()-1-SYNC_N];  pcs = q_cs[q_cs.size()-2-SYNC_N];
            cck = q_sck[q_sck.size()-1-SYNC_N]; pck = q_sck[q_sck.size()-2-SYNC_N];
            csi = q_si[q_si.size()-1-SYNC_N];
            q_cs.pop_front(); q_sck.pop_front(); q_si.pop_front();
            crise = (pcs == 0) && (ccs == 1);
            krise = (pck == 0) && (cck == 1);
            kfall = (pck == 1) && (cck == 0);
            stat = m_bp * 4 + m_wel * 2 + int'(busy);
            // output stream
            if (ccs == 1) begin
                m_oe = 0; m_so = 0; m_idx = 0; m_osh = 0;
            end else if (kfall && m_cnt >= 8 && m_op == 5) begin
                if (m_oe == 0 || m_idx == 7) begin
                    m_so = (stat >> 7) & 1; m_osh = (stat << 1) & 255;
                    m_idx = 0; m_oe = 1;
                end else begin
                    m_so = (m_osh >> 7) & 1; m_osh = (m_osh << 1) & 255;
                    m_idx++;
                end
            end
            // latch and protection
            n_wel = m_wel; n_bp = m_bp; n_nv = 0;
            if (m_busy_q == 1 && !busy) n_wel = 0;
            if (crise && !busy) begin
                if (m_cnt == 8 && m_op == 6) n_wel = 1;
                if (m_cnt == 8 && m_op == 4) n_wel = 0;
                if (m_cnt == 16 && m_op == 1 && m_wel == 1) begin
                    n_bp = (m_arg >> 2) & 3; n_nv = 1;
                end
            end
            m_wel = n_wel; m_bp = n_bp; m_nv = n_nv; m_busy_q = int'(busy);
            // input capture
            if (ccs == 1) m_cnt = 0;
            else if (krise) begin
                m_sh = ((m_sh << 1) | csi) & 255;
                if (m_cnt == 7)  m_op  = m_sh;
                if (m_cnt == 15) m_arg = m_sh;
                m_cnt++;
            end
        end
    end

    // Per-clock comparison, a quarter period after the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #(CLK_T/4);
            check("R3 so_oe", int'(so_oe), m_oe);
            if (m_oe == 1) check("R2 so bit", int'(so), m_so);
            check("R11 wr_permit", int'(wr_permit),
                  int'(m_wel == 1 && !busy && m_busy_q == 0));
            check("R8 nv_start", int'(nv_start), m_nv);
        end
    end

    always @(posedge clk) begin
        if (rst_n && nv_start) nv_seen++;
        if (rst_n && so_oe) oe_seen = 1;
    end

    // ---------------- stimulus ----------------
    task automatic spi(input logic [31:0] bits, input int nclk);
        for (int k = 0; k < 4; k++) cap[k] = 8'h00;
        oe_seen = 0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            si = (i < 32) ? bits[31-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 40) cap[(i-8)/8][7-((i-8)%8)] = so;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1; si = 1'b0;
        repeat (HALF + SYNC_N + 4) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        spi({op, 24'h0}, 8);
    endtask

    task automatic rd(input string req, input int exp);
        spi({8'h05, 24'h0}, 16);
        check(req, int'(cap[0]), exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int nv0;
        repeat (5) @(negedge clk);
        check("R12 so_oe in reset", int'(so_oe), 0);
        rst_n = 1'b1;
        #(CLK_T/4);
        check("R12 so_oe", int'(so_oe), 0);
        check("R12 wr_permit", int'(wr_permit), 0);
        check("R12 nv_start", int'(nv_start), 0);
        rd("R12 R4 reset status", 8'h08);

        cmd(8'h06);
        rd("R5 set latch", 8'h0A);
        cmd(8'h04);
        rd("R6 clear latch", 8'h08);

        spi({8'h06, 24'h0}, 7);
        rd("R7 short frame", 8'h08);
        spi({8'h06, 24'h0}, 9);
        rd("R7 long frame", 8'h08);
        spi({8'h06, 24'h0}, 16);
        rd("R7 double frame", 8'h08);
        cmd(8'h60);
        rd("R1 reversed set opcode", 8'h08);
        spi({8'hA0, 24'h0}, 24);
        check("R1 reversed read opcode no output", int'(oe_seen), 0);
        spi({8'h03, 24'h0}, 24);
        check("R3 foreign opcode no output", int'(oe_seen), 0);

        nv0 = nv_seen;
        spi({8'h01, 8'h0C, 16'h0}, 16);
        rd("R8 write without latch", 8'h08);
        check("R8 no start pulse", nv_seen, nv0);

        cmd(8'h06);
        spi({8'h01, 8'hF7, 16'h0}, 16);
        check("R8 start pulse", nv_seen, nv0 + 1);
        rd("R8 protection written", 8'h06);

        @(negedge clk) busy = 1'b1;
        #(CLK_T/4);
        check("R11 permit off while busy", int'(wr_permit), 0);
        rd("R10 R4 busy visible", 8'h07);
        cmd(8'h04);
        rd("R10 clear ignored", 8'h07);
        nv0 = nv_seen;
        spi({8'h01, 8'h08, 16'h0}, 16);
        rd("R10 write ignored", 8'h07);
        check("R10 no start pulse", nv_seen, nv0);
        @(negedge clk) busy = 1'b0;
        repeat (3) @(negedge clk);
        rd("R9 latch cleared on completion", 8'h04);

        @(negedge clk) busy = 1'b1;
        cmd(8'h06);
        rd("R10 set ignored", 8'h05);
        @(negedge clk) busy = 1'b0;
        repeat (3) @(negedge clk);

        cmd(8'h06);
        #(CLK_T/4);
        check("R11 permit on", int'(wr_permit), 1);
        spi({8'h05, 24'h0}, 32);
        check("R2 repeat byte 0", int'(cap[0]), 8'h06);
        check("R2 repeat byte 1", int'(cap[1]), 8'h06);
        check("R2 repeat byte 2", int'(cap[2]), 8'h06);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule